// File: doc/BRIEF.md
# I2C Bus Watcher with Multi-Master Arbitration

This block sits beside a two-wire I2C master, whether that master is driven bit by bit from firmware or by a hardware shifter, and observes the shared bus. Both wires pass through a synchronizer. The block then spots START and STOP conditions and keeps a start flag and a stop flag that are sticky. From those two flags it works out whether the bus is free. A single sticky interrupt flag collects three kinds of event: START, STOP, and a completed byte reported by the shifter. Firmware clears the interrupt flag by writing one to a clear input.

The local master states the level it wants on each wire, and this block turns that wish into open-drain enables. An enable is only ever asserted to pull a wire low. A high level is produced by releasing the wire. While the local side releases SDA and expects it high, the block compares the sampled SDA with that expectation at every SCL rising edge. If it finds SDA low, arbitration is lost. The block then releases both wires and records whether the loss fell in the address phase or the data phase, so that a higher layer knows whether it must retry data later.

Phase tracking begins at every START, repeated STARTs included, in the address phase. It moves to the data phase once the address byte and its acknowledge have taken nine SCL rising edges.

Top module: `i2c_bus_watch`

## Requirements
- R1: `sda_oe` is 1 only when `en`=1, `mst_act`=1, `sda_want`=0 and `arb_lost`=0. `scl_oe` follows the same rule with `scl_want`. An enable of 1 always means "pull low", and a wanted level of 1 never asserts an enable.
- R2: Both bus inputs pass through a two-flop synchronizer. A START is synchronized SDA falling while synchronized SCL stays high. A START sets `start_flag` and clears `stop_flag`. A STOP is SDA rising while SCL stays high. A STOP sets `stop_flag` and clears `start_flag`. The flags change three clock edges after the input change and hold at all other times.
- R3: While `en`=0, both flags are cleared, and START and STOP are not detected.
- R4: `bus_free` is 1 when `stop_flag`=1, or when both flags are 0. It is 0 after a START until the next STOP.
- R5: `irq` is set by a detected START, a detected STOP, or a `byte_done` pulse while `en`=1. It stays set until an `irq_clr` pulse. A set in the same cycle as a clear wins.
- R6: At each synchronized SCL rising edge with `en`=1, `mst_act`=1 and `sda_want`=1, a synchronized SDA of 0 sets `arb_lost`. When `sda_want`=0, no loss is flagged.
- R7: Once `arb_lost` is 1, both `sda_oe` and `scl_oe` are 0. `arb_lost` stays 1 until an `arb_clr` pulse.
- R8: `arb_phase` records the phase at the time of the loss: 0 for address and 1 for data. The phase is address after any START or STOP, repeated START included. It becomes data after the ninth SCL rising edge that follows a START.
- R9: If the module is enabled while another master holds the bus, the next STOP still sets `irq` and `stop_flag`, and `bus_free` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable |
| scl_in | input | 1 | Sampled SCL wire level |
| sda_in | input | 1 | Sampled SDA wire level |
| mst_act | input | 1 | Local master is driving the bus |
| scl_want | input | 1 | Level the local master wants on SCL |
| sda_want | input | 1 | Level the local master wants on SDA |
| byte_done | input | 1 | Pulse: a byte was transmitted or received |
| irq_clr | input | 1 | Write-one-to-clear for irq |
| arb_clr | input | 1 | Write-one-to-clear for arb_lost |
| scl_oe | output | 1 | SCL low-driver enable |
| sda_oe | output | 1 | SDA low-driver enable |
| start_flag | output | 1 | Sticky START seen |
| stop_flag | output | 1 | Sticky STOP seen |
| bus_free | output | 1 | Bus may be taken |
| irq | output | 1 | Sticky interrupt flag |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| arb_phase | output | 1 | Phase of the loss (0 address, 1 data) |

## Verification
START and STOP are driven both with SCL high and with SCL low. The SCL-low cases show that a real condition is told apart from an ordinary data change. Arbitration is tried in three cases: on the first address bit, after a full nine-edge address byte, and after a repeated START that follows a data phase. Together these separate the two phase tags and show that the phase is reset. A low SDA while the local side drives low shows that the check is made only while driving high. Cases that toggle the enable, including enabling in the middle of a transfer, show that the flags are cleared and that the following STOP is still reported.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
    } bus_evt_t;

    // Bus may be claimed after a STOP, or when no condition has been seen.
    function automatic logic free_of(input logic s_flag, input logic p_flag);
        return p_flag | ~s_flag;
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_cond_det.sv
module i2cw_cond_det
    import i2cw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start    = en & scl_s & scl_q &  sda_q & ~sda_s;
        evt.stop     = en & scl_s & scl_q & ~sda_q &  sda_s;
        evt.scl_rise = en & scl_s & ~scl_q;
    end
endmodule

// File: rtl/i2cw_phase.sv
module i2cw_phase
    import i2cw_pkg::*;
#(
    parameter int ADDR_EDGES = 9
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  bus_evt_t evt,
    output phase_e   phase
);
    localparam int CW = $clog2(ADDR_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(ADDR_EDGES - 1);

    logic [CW-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || evt.start || evt.stop) begin
            edge_cnt <= '0;
            phase    <= PH_ADDR;
        end else if (evt.scl_rise && phase == PH_ADDR) begin
            if (edge_cnt == LAST) begin
                edge_cnt <= '0;
                phase    <= PH_DATA;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cw_arb.sv
module i2cw_arb
    import i2cw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     mst_act,
    input  logic     sda_want,
    input  logic     sda_s,
    input  bus_evt_t evt,
    input  phase_e   phase,
    input  logic     arb_clr,
    output logic     lost,
    output phase_e   lost_phase
);
    logic mismatch;

    // Checked only while releasing SDA: a low seen there belongs to someone else.
    assign mismatch = en & mst_act & sda_want & evt.scl_rise & ~sda_s & ~lost;

    always_ff @(posedge clk) begin
        if (rst) begin
            lost       <= 1'b0;
            lost_phase <= PH_ADDR;
        end else if (mismatch) begin
            lost       <= 1'b1;
            lost_phase <= phase;
        end else if (arb_clr) begin
            lost       <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2cw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_EDGES  = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    input  logic mst_act,
    input  logic scl_want,
    input  logic sda_want,
    input  logic byte_done,
    input  logic irq_clr,
    input  logic arb_clr,
    output logic scl_oe,
    output logic sda_oe,
    output logic start_flag,
    output logic stop_flag,
    output logic bus_free,
    output logic irq,
    output logic arb_lost,
    output logic arb_phase
);
    logic [1:0] line_s;
    bus_evt_t   evt;
    phase_e     cur_phase;
    phase_e     loss_phase;

    i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (line_s)
    );

    i2cw_cond_det u_det (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .scl_s (line_s[1]),
        .sda_s (line_s[0]),
        .evt   (evt)
    );

    i2cw_phase #(.ADDR_EDGES(ADDR_EDGES)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .evt   (evt),
        .phase (cur_phase)
    );

    i2cw_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .mst_act    (mst_act),
        .sda_want   (sda_want),
        .sda_s      (line_s[0]),
        .evt        (evt),
        .phase      (cur_phase),
        .arb_clr    (arb_clr),
        .lost       (arb_lost),
        .lost_phase (loss_phase)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
        end else if (evt.start) begin
            start_flag <= 1'b1;
            stop_flag  <= 1'b0;
        end else if (evt.stop) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (evt.start || evt.stop || (en && byte_done)) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    logic drive_ok;
    assign drive_ok  = en & mst_act & ~arb_lost;
    assign sda_oe    = drive_ok & ~sda_want;
    assign scl_oe    = drive_ok & ~scl_want;
    assign bus_free  = free_of(start_flag, stop_flag);
    assign arb_phase = loss_phase;
endmodule

// File: rtl/i2cw_check.sv
module i2cw_check (
    input logic clk,
    input logic rst,
    input logic en,
    input logic scl_in,
    input logic sda_in,
    input logic mst_act,
    input logic scl_want,
    input logic sda_want,
    input logic byte_done,
    input logic irq_clr,
    input logic arb_clr,
    input logic scl_oe,
    input logic sda_oe,
    input logic start_flag,
    input logic stop_flag,
    input logic bus_free,
    input logic irq,
    input logic arb_lost,
    input logic arb_phase
);
    a_r1_never_drive_high: assert property (@(posedge clk) disable iff (rst)
        (sda_want |-> !sda_oe) and (scl_want |-> !scl_oe));

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(start_flag && stop_flag));

    a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!start_flag && !stop_flag));

    a_r4_free_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_flag) |-> bus_free);

    a_r5_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    a_r7_release_on_loss: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> (!sda_oe && !scl_oe));

    a_r7_loss_sticky: assert property (@(posedge clk) disable iff (rst)
        (arb_lost && !arb_clr) |=> arb_lost);

    a_r8_phase_held: assert property (@(posedge clk) disable iff (rst)
        (arb_lost && $past(arb_lost)) |-> $stable(arb_phase));
endmodule

bind i2c_bus_watch i2cw_check u_chk (.*);

// File: tb/tb_i2c_bus_watch.sv
`timescale 1ns/1ps
module tb_i2c_bus_watch;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, scl_in = 1'b1, sda_in = 1'b1, mst_act = 1'b0;
    logic scl_want = 1'b1, sda_want = 1'b1, byte_done = 1'b0;
    logic irq_clr = 1'b0, arb_clr = 1'b0;
    logic scl_oe, sda_oe, start_flag, stop_flag, bus_free, irq, arb_lost, arb_phase;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    i2c_bus_watch dut (.*);

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setbus(input logic scl, input logic sda);
        @(negedge clk);
        scl_in = scl;
        sda_in = sda;
        idle(4);
    endtask

    task automatic pulse_clr(input logic do_irq, input logic do_arb);
        @(negedge clk);
        irq_clr = do_irq;
        arb_clr = do_arb;
        @(negedge clk);
        irq_clr = 1'b0;
        arb_clr = 1'b0;
        idle(1);
    endtask

    task automatic do_start();
        setbus(1, 1);
        setbus(1, 0);
        setbus(0, 0);
    endtask

    task automatic do_stop();
        setbus(0, 0);
        setbus(1, 0);
        setbus(1, 1);
    endtask

    task automatic scl_pulses(input int n, input logic sda);
        for (int i = 0; i < n; i++) begin
            setbus(0, sda);
            setbus(1, sda);
        end
        setbus(0, sda);
    endtask

    task automatic t_reset();
        chk(start_flag, 0, "R2 reset start_flag");
        chk(stop_flag, 0, "R2 reset stop_flag");
        chk(bus_free, 1, "R4 reset bus_free");
        chk(irq, 0, "R5 reset irq");
        chk(arb_lost, 0, "R7 reset arb_lost");
    endtask

    task automatic t_start_stop();
        do_start();
        chk(start_flag, 1, "R2 start sets S");
        chk(stop_flag, 0, "R2 start leaves P clear");
        chk(bus_free, 0, "R4 busy after start");
        chk(irq, 1, "R5 irq on start");
        pulse_clr(1, 0);
        chk(irq, 0, "R5 irq cleared");
        // SDA toggles with SCL low: data, not a condition
        setbus(0, 1);
        setbus(0, 0);
        chk(irq, 0, "R2 SDA change with SCL low ignored");
        chk(start_flag, 1, "R2 S held");
        do_stop();
        chk(stop_flag, 1, "R2 stop sets P");
        chk(start_flag, 0, "R2 stop clears S");
        chk(bus_free, 1, "R4 free after stop");
        chk(irq, 1, "R5 irq on stop");
        pulse_clr(1, 0);
    endtask

    task automatic t_byte_done();
        @(negedge clk);
        byte_done = 1'b1;
        irq_clr = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        irq_clr = 1'b0;
        idle(1);
        chk(irq, 1, "R5 byte_done sets irq, set beats clear");
        pulse_clr(1, 0);
        chk(irq, 0, "R5 irq cleared after byte");
    endtask

    task automatic t_disable();
        do_start();
        pulse_clr(1, 0);
        @(negedge clk);
        en = 1'b0;
        idle(2);
        chk(start_flag, 0, "R3 disable clears S");
        chk(bus_free, 1, "R3 free while disabled");
        do_stop();
        chk(stop_flag, 0, "R3 stop ignored while disabled");
        chk(irq, 0, "R3 no irq while disabled");
        mst_act = 1'b1; sda_want = 1'b0; scl_want = 1'b0;
        idle(1);
        chk(sda_oe, 0, "R1 no drive while disabled");
        mst_act = 1'b0; sda_want = 1'b1; scl_want = 1'b1;
    endtask

    task automatic t_enable_busy();
        // another master starts while disabled
        do_start();
        @(negedge clk);
        en = 1'b1;
        idle(2);
        chk(start_flag, 0, "R9 START before enable not seen");
        chk(irq, 0, "R9 no irq at enable");
        scl_pulses(3, 0);
        do_stop();
        chk(irq, 1, "R9 stop after enable raises irq");
        chk(bus_free, 1, "R9 bus free after stop");
        pulse_clr(1, 0);
    endtask

    task automatic t_open_drain();
        mst_act = 1'b1;
        sda_want = 1'b0; scl_want = 1'b0;
        idle(1);
        chk(sda_oe, 1, "R1 SDA low drives");
        chk(scl_oe, 1, "R1 SCL low drives");
        sda_want = 1'b1; scl_want = 1'b1;
        idle(1);
        chk(sda_oe, 0, "R1 SDA high releases");
        chk(scl_oe, 0, "R1 SCL high releases");
        mst_act = 1'b0;
    endtask

    task automatic t_arb_addr();
        do_start();
        mst_act = 1'b1; scl_want = 1'b0;
        // local drives low, bus low: no loss
        sda_want = 1'b0;
        setbus(1, 0);
        chk(arb_lost, 0, "R6 no check while driving low");
        setbus(0, 0);
        // local releases, other master pulls low
        sda_want = 1'b1;
        setbus(1, 0);
        chk(arb_lost, 1, "R6 loss in address phase");
        chk(arb_phase, 0, "R8 phase tag address");
        chk(scl_oe, 0, "R7 SCL released on loss");
        sda_want = 1'b0;
        idle(1);
        chk(sda_oe, 0, "R7 SDA released on loss");
        mst_act = 1'b0; sda_want = 1'b1; scl_want = 1'b1;
        do_stop();
        pulse_clr(1, 1);
        chk(arb_lost, 0, "R7 arb_clr clears loss");
    endtask

    task automatic t_arb_data();
        do_start();
        scl_pulses(9, 0);
        mst_act = 1'b1; sda_want = 1'b1;
        setbus(1, 0);
        chk(arb_lost, 1, "R6 loss in data phase");
        chk(arb_phase, 1, "R8 phase tag data");
        mst_act = 1'b0;
        do_stop();
        pulse_clr(1, 1);
    endtask

    task automatic t_repeated_start();
        do_start();
        scl_pulses(9, 0);
        // repeated START
        setbus(0, 1);
        setbus(1, 1);
        setbus(1, 0);
        chk(start_flag, 1, "R8 repeated start seen");
        setbus(0, 0);
        mst_act = 1'b1; sda_want = 1'b1;
        setbus(1, 0);
        chk(arb_lost, 1, "R8 loss after repeated start");
        chk(arb_phase, 0, "R8 repeated start resets to address");
        mst_act = 1'b0;
        do_stop();
        pulse_clr(1, 1);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        en = 1'b1;
        idle(2);
        t_reset();
        t_start_stop();
        t_byte_done();
        t_disable();
        t_enable_busy();
        t_open_drain();
        t_arb_addr();
        t_arb_data();
        t_repeated_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule